// File: doc/BRIEF.md
# Synchronous Duplex Serial Transceiver

This block moves 8-bit frames over a three-wire clocked serial link. It transmits and receives at the same time and generates the serial clock itself. A processor reaches it through a small register window: control, status, data and clock divisor. Each direction is double-buffered. A byte written to the data location waits in a holding register while the previous byte shifts out. A received byte sits in a receive holding register while the next one shifts in.

Software, or a DMA engine woken by the interrupt lines, keeps each direction fed. Three status flags carry the handshake: transmit-empty, receive-full and overrun. An overrun freezes the link until software acknowledges it. Full-duplex operation starts only when both enables are switched on together from the fully disabled state.

All bus accesses last one cycle. The read data is combinational from the address. Reset is synchronous and active low.

Top module: `sync_duplex_serial`

## Requirements
- R1: After reset, status (address 1) reads 0x01 (only transmit-empty set), control (address 0) and the receive data (address 2) read 0, the serial clock and the serial data output are high, and both interrupt lines are low.
- R2: A frame is 8 bits, LSB first. For each bit the serial clock is low for div+1 system clocks and then high for div+1 system clocks, where div is the value at address 3. The output bit changes as the clock falls.
- R3: The serial input is sampled as the serial clock rises and assembled LSB first. At the end of the frame, with receive enabled (control bit 1) and the receive-full flag (status bit 1) clear, the byte moves to the receive data register and receive-full is set.
- R4: Transmit-empty (status bit 0) is set when the holding byte moves into the shifter at frame start. The transmit interrupt line equals transmit-empty AND transmit enable (control bit 0).
- R5: The receive interrupt line equals receive-full AND receive enable.
- R6: A status flag clears only when a CPU read of status saw it as 1 and a later status write carries 0 in its position. Writing 1, or writing 0 without that earlier read, leaves the flag unchanged.
- R7: A frame starts when transmit is enabled and transmit-empty is clear. If transmit-empty was cleared again before the last bit ends, the next frame follows with no idle time. Otherwise the serial clock stays high after the frame.
- R8: If a frame ends while receive-full is still set, overrun (status bit 2) is set, the receive data register keeps its old byte and the new byte is lost.
- R9: While overrun is set, no frame starts, even with transmit data pending. Once overrun is cleared, a pending frame starts.
- R10: When exactly one enable is on, a control write can clear enables but cannot set the other one. A write with both enable bits set takes effect only when both were off.
- R11: A DMA-qualified write to address 2 while the transmit interrupt is active clears transmit-empty. A DMA-qualified read of address 2 while the receive interrupt is active clears receive-full.
- R12: With only receive enabled and no overrun, frames run back to back with the serial data output held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_dma | input | 1 | Marks the access as issued by a DMA engine |
| bus_addr | input | 2 | 0 control, 1 status, 2 data, 3 divisor |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| sclk_o | output | 1 | Serial clock, idle high |
| sdo_o | output | 1 | Serial data output |
| sdi_i | input | 1 | Serial data input |

## Verification
A frame phase that is wrong by one cycle shows up on the serial clock at the next divisor tick, within div+1 clocks. A wrong shift or bit count corrupts the serial output within one bit time, and the looped-back byte read at address 2 within the same frame. Wrong flag or arm state shows on the interrupt lines and on the status read at once. A missed overrun or stall shows one frame later as a clock edge where the link should be silent. The bench loops the output back, optionally inverted, so receive and transmit errors both reach the comparison every cycle.

// File: rtl/ssx_pkg.sv
// Package: shared types and register map for the synchronous duplex
// serial transceiver. Assumes a two-bit word address.
package ssx_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } ssx_phase_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    localparam int B_TX   = 0;  // control: transmit enable / status: tx empty
    localparam int B_RX   = 1;  // control: receive enable / status: rx full
    localparam int B_OVR  = 2;  // status: overrun
endpackage

// File: rtl/ssx_baud.sv
// Half-period timer: while a frame runs, pulses tick every div+1 clocks.
// Assumes div is not rewritten while a frame is in progress.
module ssx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count system clocks inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ssx_engine.sv
// Frame engine: clock phases, transmit and receive shifters, frame start,
// chaining and end-of-frame delivery. Assumes flags come from ssx_regs and
// that the transmit holding byte is stable when load_tx fires.
module ssx_engine
    import ssx_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          te,
    input  logic          re,
    input  logic          txe,
    input  logic          rxf,
    input  logic          ovr,
    input  logic [FW-1:0] tdr,
    input  logic          tick,
    input  logic          sdi,
    output logic          run,
    output logic          sclk,
    output logic          sdo,
    output logic          load_tx,
    output logic          rx_done,
    output logic [FW-1:0] rx_byte
);
    localparam int BW = (FW > 1) ? $clog2(FW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);

    ssx_phase_e    phase;
    logic [BW-1:0] bitn;
    logic [FW-1:0] txs;
    logic [FW-1:0] rxs;

    logic any_en, go, last, chain, start;

    assign any_en  = te || re;
    assign go      = !ovr && ((te && !txe) || (re && !te));
    assign last    = (phase == PH_HIGH) && tick && (bitn == LAST_BIT) && any_en;
    assign chain   = go && !(re && rxf);
    assign start   = ((phase == PH_IDLE) && go) || (last && chain);
    assign load_tx = start && te;
    assign rx_done = last && re;
    assign rx_byte = rxs;
    assign run     = (phase != PH_IDLE);
    assign sclk    = (phase != PH_LOW);
    assign sdo     = (run && te) ? txs[0] : 1'b1;

    // Advance the frame: start or chain, abort on disable, step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            bitn  <= '0;
            txs   <= '1;
            rxs   <= '0;
        end else if (start) begin
            phase <= PH_LOW;
            bitn  <= '0;
            txs   <= tdr;
        end else if (run && !any_en) begin
            phase <= PH_IDLE;
        end else if (tick) begin
            case (phase)
                PH_LOW: begin
                    rxs   <= {sdi, rxs[FW-1:1]};
                    phase <= PH_HIGH;
                end
                PH_HIGH: begin
                    if (bitn == LAST_BIT) begin
                        phase <= PH_IDLE;
                    end else begin
                        bitn  <= bitn + 1'b1;
                        txs   <= txs >> 1;
                        phase <= PH_LOW;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: a clock phase holds until the timer ticks.
    a_r2_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && !tick && any_en && !start) |=> (phase == $past(phase)));

    // R2: the bit index never moves outside a tick.
    a_r2_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(bitn));
endmodule

// File: rtl/ssx_regs.sv
// Register window: control with enable gating, divisor, transmit and receive
// holding registers, status flags with read-then-write clearing, DMA auto
// clear and interrupt lines. Assumes at most one bus strobe per cycle.
module ssx_regs
    import ssx_pkg::*;
#(
    parameter int FW    = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic             dma,
    input  logic [1:0]       addr,
    input  logic [FW-1:0]    wdata,
    output logic [FW-1:0]    rdata,
    input  logic             load_tx,
    input  logic             rx_done,
    input  logic [FW-1:0]    rx_byte,
    output logic             te,
    output logic             re,
    output logic             txe,
    output logic             rxf,
    output logic             ovr,
    output logic [FW-1:0]    tdr,
    output logic [DIV_W-1:0] div,
    output logic             irq_txe,
    output logic             irq_rxf
);
    logic [FW-1:0] rdr;
    logic arm_txe, arm_rxf, arm_ovr;
    logic ctrl_wr, stat_wr, stat_rd, data_wr, data_rd, div_wr;

    assign ctrl_wr = wr && (addr == A_CTRL);
    assign stat_wr = wr && (addr == A_STAT);
    assign stat_rd = rd && (addr == A_STAT) && !dma;
    assign data_wr = wr && (addr == A_DATA);
    assign data_rd = rd && (addr == A_DATA);
    assign div_wr  = wr && (addr == A_DIV);

    assign irq_txe = txe && te;
    assign irq_rxf = rxf && re;

    // Enables: set freely only from the all-off state, otherwise only clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te <= 1'b0;
            re <= 1'b0;
        end else if (ctrl_wr) begin
            if (!te && !re) begin
                te <= wdata[B_TX];
                re <= wdata[B_RX];
            end else begin
                te <= te && wdata[B_TX];
                re <= re && wdata[B_RX];
            end
        end
    end

    // Divisor and transmit holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div <= '0;
            tdr <= '0;
        end else begin
            if (div_wr)  div <= wdata[DIV_W-1:0];
            if (data_wr) tdr <= wdata;
        end
    end

    // Flags, arm bits and receive holding register; engine events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe     <= 1'b1;
            rxf     <= 1'b0;
            ovr     <= 1'b0;
            arm_txe <= 1'b0;
            arm_rxf <= 1'b0;
            arm_ovr <= 1'b0;
            rdr     <= '0;
        end else begin
            if (stat_rd) begin
                arm_txe <= arm_txe || txe;
                arm_rxf <= arm_rxf || rxf;
                arm_ovr <= arm_ovr || ovr;
            end
            if (stat_wr) begin
                if (arm_txe && !wdata[B_TX])  txe <= 1'b0;
                if (arm_rxf && !wdata[B_RX])  rxf <= 1'b0;
                if (arm_ovr && !wdata[B_OVR]) ovr <= 1'b0;
                arm_txe <= 1'b0;
                arm_rxf <= 1'b0;
                arm_ovr <= 1'b0;
            end
            if (data_wr && dma && irq_txe) txe <= 1'b0;
            if (data_rd && dma && irq_rxf) rxf <= 1'b0;
            if (load_tx) txe <= 1'b1;
            if (rx_done) begin
                if (rxf) begin
                    ovr <= 1'b1;
                end else begin
                    rdr <= rx_byte;
                    rxf <= 1'b1;
                end
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_TX] = te;
                rdata[B_RX] = re;
            end
            A_STAT: begin
                rdata[B_TX]  = txe;
                rdata[B_RX]  = rxf;
                rdata[B_OVR] = ovr;
            end
            A_DATA:  rdata = rdr;
            default: rdata[DIV_W-1:0] = div;
        endcase
    end

    // R3: a delivered frame lands in the holding register and sets the flag.
    a_r3_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rxf) |=> (rxf && rdr == $past(rx_byte)));

    // R8: a frame ending on a full buffer is dropped and flags overrun.
    a_r8_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rxf) |=> (ovr && rdr == $past(rdr)));

    // R6: writing 1 over a set transmit-empty flag leaves it set.
    a_r6_write_one: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[B_TX] && txe) |=> txe);

    // R10: with one enable on, no control write turns both on.
    a_r10_no_late_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (te != re)) |=> !(te && re));
endmodule

// File: rtl/sync_duplex_serial.sv
// Top: clocked serial transceiver with double buffering in both directions,
// generated serial clock (idle high) and flag/interrupt handshake.
// Assumes a single bus master strobe per cycle.
module sync_duplex_serial
    import ssx_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_dma,
    input  logic [1:0]         bus_addr,
    input  logic [FRAME_W-1:0] bus_wdata,
    output logic [FRAME_W-1:0] bus_rdata,
    output logic               irq_tx_empty,
    output logic               irq_rx_full,
    output logic               sclk_o,
    output logic               sdo_o,
    input  logic               sdi_i
);
    logic               te, re, txe, rxf, ovr;
    logic [FRAME_W-1:0] tdr, rx_byte;
    logic [DIV_W-1:0]   div;
    logic               run, tick, load_tx, rx_done;

    ssx_regs #(.FW(FRAME_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr), .rd(bus_rd), .dma(bus_dma), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .load_tx(load_tx), .rx_done(rx_done), .rx_byte(rx_byte),
        .te(te), .re(re), .txe(txe), .rxf(rxf), .ovr(ovr),
        .tdr(tdr), .div(div),
        .irq_txe(irq_tx_empty), .irq_rxf(irq_rx_full)
    );

    ssx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
    );

    ssx_engine #(.FW(FRAME_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .te(te), .re(re), .txe(txe), .rxf(rxf), .ovr(ovr),
        .tdr(tdr), .tick(tick), .sdi(sdi_i),
        .run(run), .sclk(sclk_o), .sdo(sdo_o),
        .load_tx(load_tx), .rx_done(rx_done), .rx_byte(rx_byte)
    );

    // R9: nothing is loaded for transmission while overrun stands.
    a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> !load_tx);

    // R4: moving the holding byte into the shifter sets transmit-empty.
    a_r4_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        load_tx |=> txe);
endmodule

// File: tb/sync_duplex_serial_test.sv
module sync_duplex_serial_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_wr = 1'b0, b_rd = 1'b0, b_dma = 1'b0;
    logic [1:0] b_addr = 2'd0;
    logic [7:0] b_wd = 8'd0;
    logic [7:0] rdata;
    logic       irq_t, irq_r, sclk, sdo, sdi;
    logic       inv = 1'b0;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit finished = 1'b0;

    assign sdi = sdo ^ inv;

    sync_duplex_serial uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd), .bus_dma(b_dma),
        .bus_addr(b_addr), .bus_wdata(b_wd), .bus_rdata(rdata),
        .irq_tx_empty(irq_t), .irq_rx_full(irq_r),
        .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit m_te, m_re, m_txe, m_rxf, m_ovr, a_t, a_r, a_o;
    logic [7:0] m_div, m_tdr, m_rdr, m_txq, m_rxacc;
    int m_busy, m_cnt, m_bit, nb;   // busy: 0 idle, 1 clock low, 2 clock high
    bit go, tk, ld, dn, s_in, o_txe, o_rxf, o_te, o_re;

    function automatic bit ref_sdo();
        return (m_busy != 0 && m_te) ? m_txq[0] : 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_te = 0; m_re = 0; m_txe = 1; m_rxf = 0; m_ovr = 0;
            a_t = 0; a_r = 0; a_o = 0;
            m_div = 0; m_tdr = 0; m_rdr = 0; m_txq = 8'hFF; m_rxacc = 0;
            m_busy = 0; m_cnt = 0; m_bit = 0;
        end else begin
            s_in = ref_sdo() ^ inv;
            go = !m_ovr && ((m_te && !m_txe) || (m_re && !m_te));
            tk = (m_busy != 0) && (m_cnt == int'(m_div));
            ld = 0; dn = 0; nb = m_busy;
            if (m_busy == 0) ld = go;
            else if (!m_te && !m_re) nb = 0;
            else if (tk) begin
                if (m_busy == 1) begin
                    m_rxacc = {s_in, m_rxacc[7:1]};
                    nb = 2;
                end else if (m_bit == 7) begin
                    dn = m_re;
                    if (go && !(m_re && m_rxf)) ld = 1; else nb = 0;
                end else begin
                    m_bit++; m_txq = m_txq >> 1; nb = 1;
                end
            end
            m_cnt = (m_busy == 0 || tk) ? 0 : m_cnt + 1;
            if (ld) begin nb = 1; m_bit = 0; m_txq = m_tdr; end
            m_busy = nb;
            o_txe = m_txe; o_rxf = m_rxf; o_te = m_te; o_re = m_re;
            if (b_wr) begin
                case (b_addr)
                    2'd0: if (!o_te && !o_re) begin m_te = b_wd[0]; m_re = b_wd[1]; end
                          else begin m_te = o_te && b_wd[0]; m_re = o_re && b_wd[1]; end
                    2'd1: begin
                        if (a_t && !b_wd[0]) m_txe = 0;
                        if (a_r && !b_wd[1]) m_rxf = 0;
                        if (a_o && !b_wd[2]) m_ovr = 0;
                        a_t = 0; a_r = 0; a_o = 0;
                    end
                    2'd2: begin m_tdr = b_wd; if (b_dma && o_te && o_txe) m_txe = 0; end
                    default: m_div = b_wd;
                endcase
            end
            if (b_rd && b_addr == 2'd1 && !b_dma) begin
                a_t = a_t || o_txe; a_r = a_r || o_rxf; a_o = a_o || m_ovr;
            end
            if (b_rd && b_addr == 2'd2 && b_dma && o_re && o_rxf) m_rxf = 0;
            if (ld && o_te) m_txe = 1;
            if (dn) begin
                if (o_rxf) m_ovr = 1;
                else begin m_rdr = m_rxacc; m_rxf = 1; end
            end
        end
    end

    // Every-cycle comparison against the reference, away from the edge.
    logic [7:0] exp_rd;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            case (b_addr)
                2'd0: exp_rd = {6'd0, m_re, m_te};
                2'd1: exp_rd = {5'd0, m_ovr, m_rxf, m_txe};
                2'd2: exp_rd = m_rdr;
                default: exp_rd = m_div;
            endcase
            chk(sclk == (m_busy != 1), "R2 sclk", sclk, m_busy != 1);
            chk(sdo == ref_sdo(), "R2 sdo", sdo, ref_sdo());
            chk(irq_t == (m_txe && m_te), "R4 irq_tx", irq_t, m_txe && m_te);
            chk(irq_r == (m_rxf && m_re), "R5 irq_rx", irq_r, m_rxf && m_re);
            chk(rdata == exp_rd, "R6 rdata", rdata, exp_rd);
        end
    end

    // Frame monitor on the serial side.
    logic [7:0] cap = 0, mon_last = 0;
    int nedge = 0, mon_frames = 0, last_cyc = 0, prev_cyc = 0;
    always @(posedge sclk) begin
        if (rst_n) begin
            cap = {sdo, cap[7:1]};
            nedge++;
            if (nedge % 8 == 0) begin
                mon_last = cap; mon_frames++;
                prev_cyc = last_cyc; last_cyc = cyc;
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic slot();
        @(posedge clk); #(CLK_P/4);
    endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit dm);
        slot(); b_wr = 1; b_addr = a; b_wd = d; b_dma = dm;
        slot(); b_wr = 0; b_dma = 0;
    endtask
    task automatic rd(input logic [1:0] a, input bit dm);
        slot(); b_rd = 1; b_addr = a; b_dma = dm;
        slot(); b_rd = 0; b_dma = 0;
    endtask
    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        slot(); b_addr = a; #1 v = rdata;
    endtask
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    logic [7:0] v;
    initial begin
        idle(4);
        slot(); rst_n = 1;
        // R1: reset state
        peek(2'd1, v); chk(v == 8'h01, "R1 status", v, 8'h01);
        peek(2'd0, v); chk(v == 8'h00, "R1 control", v, 0);
        peek(2'd2, v); chk(v == 8'h00, "R1 rx data", v, 0);
        chk(sclk && sdo && !irq_t && !irq_r, "R1 pins", {sclk, sdo, irq_t, irq_r}, 4'b1100);

        // R2/R4: single transmit frame, divisor 1
        wr(2'd3, 8'd1, 0);
        wr(2'd0, 8'h01, 0);
        wr(2'd2, 8'hA5, 0);
        rd(2'd1, 0); wr(2'd1, 8'h06, 0);
        idle(40);
        chk(mon_last == 8'hA5, "R2 tx byte", mon_last, 8'hA5);
        chk(irq_t == 1, "R4 irq after load", irq_t, 1);

        // R6: write 1 and unarmed write 0 do not clear
        rd(2'd1, 0); wr(2'd1, 8'h07, 0);
        peek(2'd1, v); chk(v[0] == 1, "R6 write one", v, 8'h01);
        wr(2'd1, 8'h00, 0);
        peek(2'd1, v); chk(v[0] == 1, "R6 unarmed zero", v, 8'h01);

        // R7: chained frames without gap
        wr(2'd2, 8'h11, 0); rd(2'd1, 0); wr(2'd1, 8'h00, 0);
        wr(2'd2, 8'h22, 0); rd(2'd1, 0); wr(2'd1, 8'h00, 0);
        idle(80);
        chk(mon_last == 8'h22, "R7 second byte", mon_last, 8'h22);
        chk(last_cyc - prev_cyc == 32, "R7 no gap", last_cyc - prev_cyc, 32);
        chk(sclk == 1, "R7 stop when empty", sclk, 1);

        // R10: enable gating
        wr(2'd0, 8'h03, 0);
        peek(2'd0, v); chk(v == 8'h01, "R10 late enable refused", v, 8'h01);
        wr(2'd0, 8'h00, 0); wr(2'd0, 8'h03, 0);
        peek(2'd0, v); chk(v == 8'h03, "R10 duplex from off", v, 8'h03);

        // R3/R5: duplex with inverted loopback
        inv = 1;
        wr(2'd2, 8'h3C, 0); rd(2'd1, 0); wr(2'd1, 8'h00, 0);
        idle(50);
        peek(2'd2, v); chk(v == 8'hC3, "R3 rx byte", v, 8'hC3);
        peek(2'd1, v); chk(v == 8'h03, "R3 status", v, 8'h03);
        chk(irq_r == 1, "R5 irq rx", irq_r, 1);

        // R8: overrun keeps old byte
        wr(2'd2, 8'h0F, 0); rd(2'd1, 0); wr(2'd1, 8'h02, 0);
        idle(50);
        peek(2'd1, v); chk(v == 8'h07, "R8 overrun flag", v, 8'h07);
        peek(2'd2, v); chk(v == 8'hC3, "R8 old byte kept", v, 8'hC3);

        // R9: halted while overrun, resumes after clearing
        wr(2'd2, 8'h55, 0); rd(2'd1, 0); wr(2'd1, 8'h06, 0);
        idle(60);
        peek(2'd1, v); chk(v == 8'h06, "R9 halted", v, 8'h06);
        chk(sclk == 1, "R9 clock idle", sclk, 1);
        rd(2'd1, 0); wr(2'd1, 8'h01, 0);
        idle(40);
        peek(2'd2, v); chk(v == 8'hAA, "R9 resumed rx", v, 8'hAA);
        chk(mon_last == 8'h55, "R9 resumed tx", mon_last, 8'h55);

        // R11: DMA accesses clear flags
        rd(2'd2, 1);
        peek(2'd1, v); chk(v == 8'h01, "R11 dma read clears rx full", v, 8'h01);
        wr(2'd2, 8'h81, 1);
        idle(40);
        chk(mon_last == 8'h81, "R11 dma write starts frame", mon_last, 8'h81);
        peek(2'd2, v); chk(v == 8'h7E, "R11 rx byte", v, 8'h7E);

        // R12: receive-only runs back to back
        wr(2'd0, 8'h00, 0);
        rd(2'd1, 0); wr(2'd1, 8'h01, 0);
        inv = 0;
        wr(2'd0, 8'h02, 0);
        idle(40);
        peek(2'd1, v); chk(v == 8'h03, "R12 first frame", v, 8'h03);
        peek(2'd2, v); chk(v == 8'hFF, "R12 rx byte", v, 8'hFF);
        idle(40);
        peek(2'd1, v); chk(v == 8'h07, "R12 second frame overruns", v, 8'h07);
        chk(sdo == 1, "R12 sdo held", sdo, 1);

        idle(5);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule